// File: doc/BRIEF.md
# Reservation Station Pool

This block parks dispatched instructions in a small set of station slots until both source operands hold values, then hands one ready instruction per cycle to a single functional unit. Each slot keeps an opcode, two source operands (each a producer tag, a data word and a valid bit) and a destination tag. A source that already has its value at dispatch time arrives valid. A source that is still pending waits on the result bus, which carries (tag, value) pairs from completing instructions.

On every result broadcast, each pending source whose tag equals the broadcast tag takes the value and becomes valid. This includes a source being written into the pool in that same cycle. The pool keeps no arrival order. Whenever the functional unit signals it is free, the lowest-numbered slot whose operands are both valid is issued, and that slot is released at the same clock edge. Dispatch is refused when every slot is occupied. Tag allocation and execution are done elsewhere.

Top module: `rs_pool`

## Requirements
- R1: After reset no slot is occupied, `iss_valid_o` is 0 and `disp_ready_o` is 1.
- R2: A dispatch is accepted at a rising edge when `disp_valid_i` and `disp_ready_o` are both 1, and it is written into the lowest-numbered free slot. `disp_ready_o` is 0 exactly when all NUM_ENTRIES slots (default 4) are occupied.
- R3: A source whose ready flag is 1 at dispatch is stored as valid with the dispatched data. An instruction dispatched with both flags set is issuable in the cycle after dispatch, with no broadcast.
- R4: A broadcast with `bc_valid_i`=1 sets data and valid on every occupied slot's pending source whose tag equals `bc_tag_i`. A broadcast whose tag matches no pending source changes nothing.
- R5: A broadcast in the same cycle as a dispatch also completes a pending source of the instruction being dispatched when the tags match.
- R6: `iss_valid_o` is 1 only while `fu_free_i` is 1 and some occupied slot has both sources valid. It is 1 whenever both of those hold.
- R7: When several slots are ready, the lowest-numbered one issues, regardless of which was dispatched first.
- R8: The issued slot is released at the edge where `iss_valid_o` is 1, and it is free for dispatch in the next cycle.
- R9: While `iss_valid_o` is 1, the issue outputs carry the issuing slot's opcode, source 1 value, source 2 value and destination tag.
- R10: A dispatch offered while `disp_ready_o` is 0 has no effect: the instruction is never stored and never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | At least one slot is free |
| disp_op_i | input | OP_W (4) | Opcode |
| disp_src1_tag_i | input | TAG_W (3) | Producer tag of source 1 |
| disp_src1_data_i | input | DATA_W (16) | Source 1 value when ready |
| disp_src1_rdy_i | input | 1 | Source 1 value already available |
| disp_src2_tag_i | input | TAG_W (3) | Producer tag of source 2 |
| disp_src2_data_i | input | DATA_W (16) | Source 2 value when ready |
| disp_src2_rdy_i | input | 1 | Source 2 value already available |
| disp_dst_tag_i | input | TAG_W (3) | Destination tag |
| bc_valid_i | input | 1 | Result broadcast present |
| bc_tag_i | input | TAG_W (3) | Tag of broadcast result |
| bc_data_i | input | DATA_W (16) | Broadcast result value |
| fu_free_i | input | 1 | Functional unit can accept an instruction |
| iss_valid_o | output | 1 | Instruction issued this cycle |
| iss_op_o | output | OP_W (4) | Issued opcode |
| iss_src1_o | output | DATA_W (16) | Issued source 1 value |
| iss_src2_o | output | DATA_W (16) | Issued source 2 value |
| iss_dst_tag_o | output | TAG_W (3) | Issued destination tag |

## Verification
Two cases are hard to reach from the ports. The first is a younger instruction issuing ahead of older ones that are still waiting. The second is a broadcast that lands in the same cycle as the dispatch of one of its consumers into a slot freed by the issue just before. A directed sequence holds the functional unit busy and fills every slot with pending sources. It then offers a dispatch to the full pool, wakes only the third slot, and broadcasts while dispatching into the freed slot. A long random phase then draws tags from a small set, so that matches, shared tags and full-pool refusals occur often, and compares every cycle against a bench model.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int OP_W   = 4;
  parameter int TAG_W  = 3;
  parameter int DATA_W = 16;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [TAG_W-1:0]  t1;
    logic [DATA_W-1:0] d1;
    logic              v1;
    logic [TAG_W-1:0]  t2;
    logic [DATA_W-1:0] d2;
    logic              v2;
    logic [TAG_W-1:0]  dst;
  } rs_slot_t;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  rs_slot_t          disp_i,
  input  logic              clear_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              busy_o,
  output logic              ready_o,
  output rs_slot_t          slot_o
);
  logic     busy_q;
  rs_slot_t slot_q;
  rs_slot_t snoop_disp, snoop_held;

  // complete pending sources from the result bus
  function automatic rs_slot_t wake(rs_slot_t s, logic bv, logic [TAG_W-1:0] bt,
                                    logic [DATA_W-1:0] bd);
    rs_slot_t r = s;
    if (bv && !s.v1 && s.t1 == bt) begin
      r.v1 = 1'b1;
      r.d1 = bd;
    end
    if (bv && !s.v2 && s.t2 == bt) begin
      r.v2 = 1'b1;
      r.d2 = bd;
    end
    return r;
  endfunction

  assign snoop_disp = wake(disp_i, bc_valid_i, bc_tag_i, bc_data_i);
  assign snoop_held = wake(slot_q, bc_valid_i, bc_tag_i, bc_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      slot_q <= snoop_disp;
    end else begin
      if (clear_i) busy_q <= 1'b0;
      if (busy_q)  slot_q <= snoop_held;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q & slot_q.v1 & slot_q.v2;
  assign slot_o  = slot_q;

  AST_NO_DOUBLE_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q); // R2
  AST_WAKE_SRC1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && !clear_i && bc_valid_i && !slot_q.v1 && slot_q.t1 == bc_tag_i)
    |=> (slot_q.v1 && slot_q.d1 == $past(bc_data_i))); // R4
  AST_WAKE_SRC2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && !clear_i && bc_valid_i && !slot_q.v2 && slot_q.t2 == bc_tag_i)
    |=> (slot_q.v2 && slot_q.d2 == $past(bc_data_i))); // R4
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && !clear_i && slot_q.v1 && slot_q.v2) |=> ready_o); // R4
  AST_SAME_CYCLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && bc_valid_i && !disp_i.v1 && disp_i.t1 == bc_tag_i)
    |=> (slot_q.v1 && slot_q.d1 == $past(bc_data_i))); // R5
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  output logic              disp_ready_o,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic [TAG_W-1:0]  disp_src1_tag_i,
  input  logic [DATA_W-1:0] disp_src1_data_i,
  input  logic              disp_src1_rdy_i,
  input  logic [TAG_W-1:0]  disp_src2_tag_i,
  input  logic [DATA_W-1:0] disp_src2_data_i,
  input  logic              disp_src2_rdy_i,
  input  logic [TAG_W-1:0]  disp_dst_tag_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              fu_free_i,
  output logic              iss_valid_o,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [DATA_W-1:0] iss_src1_o,
  output logic [DATA_W-1:0] iss_src2_o,
  output logic [TAG_W-1:0]  iss_dst_tag_o
);
  logic [NUM_ENTRIES-1:0] busy_vec, rdy_vec;
  logic [NUM_ENTRIES-1:0] free_gnt, iss_gnt;
  logic [IDX_W-1:0]       free_idx, iss_idx;
  logic                   any_free, any_rdy, disp_fire;
  rs_slot_t               slot_vec [NUM_ENTRIES];
  rs_slot_t               disp_slot;

  always_comb begin
    disp_slot.op  = disp_op_i;
    disp_slot.t1  = disp_src1_tag_i;
    disp_slot.d1  = disp_src1_data_i;
    disp_slot.v1  = disp_src1_rdy_i;
    disp_slot.t2  = disp_src2_tag_i;
    disp_slot.d2  = disp_src2_data_i;
    disp_slot.v2  = disp_src2_rdy_i;
    disp_slot.dst = disp_dst_tag_i;
  end

  rs_pick #(.N(NUM_ENTRIES)) u_free_pick (
    .req_i(~busy_vec), .gnt_o(free_gnt), .idx_o(free_idx), .any_o(any_free));

  rs_pick #(.N(NUM_ENTRIES)) u_iss_pick (
    .req_i(rdy_vec), .gnt_o(iss_gnt), .idx_o(iss_idx), .any_o(any_rdy));

  assign disp_ready_o = any_free;
  assign disp_fire    = disp_valid_i & any_free;
  assign iss_valid_o  = any_rdy & fu_free_i;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    rs_entry u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (disp_fire & free_gnt[g]),
      .disp_i    (disp_slot),
      .clear_i   (iss_valid_o & iss_gnt[g]),
      .bc_valid_i(bc_valid_i),
      .bc_tag_i  (bc_tag_i),
      .bc_data_i (bc_data_i),
      .busy_o    (busy_vec[g]),
      .ready_o   (rdy_vec[g]),
      .slot_o    (slot_vec[g])
    );
  end

  assign iss_op_o      = slot_vec[iss_idx].op;
  assign iss_src1_o    = slot_vec[iss_idx].d1;
  assign iss_src2_o    = slot_vec[iss_idx].d2;
  assign iss_dst_tag_o = slot_vec[iss_idx].dst;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && !disp_ready_o && !iss_valid_o) |=> $stable(busy_vec)); // R10
  AST_ISSUE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |=> !busy_vec[$past(iss_idx)]); // R8
  AST_OCCUPANCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(busy_vec) == $past($countones(busy_vec))
              + $past(int'(disp_fire)) - $past(int'(iss_valid_o)))); // R2
  AST_ISSUE_OPERANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (slot_vec[iss_idx].v1 && slot_vec[iss_idx].v2)); // R6
endmodule

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
  import rs_pkg::*;
  localparam int NE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              disp_valid, disp_ready, s1_rdy, s2_rdy, bc_valid, fu_free;
  logic [OP_W-1:0]   op;
  logic [TAG_W-1:0]  t1, t2, dst, bc_tag;
  logic [DATA_W-1:0] d1, d2, bc_data;
  logic              iss_valid;
  logic [OP_W-1:0]   iss_op;
  logic [DATA_W-1:0] iss_s1, iss_s2;
  logic [TAG_W-1:0]  iss_dst;

  rs_pool #(.NUM_ENTRIES(NE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_ready_o(disp_ready), .disp_op_i(op),
    .disp_src1_tag_i(t1), .disp_src1_data_i(d1), .disp_src1_rdy_i(s1_rdy),
    .disp_src2_tag_i(t2), .disp_src2_data_i(d2), .disp_src2_rdy_i(s2_rdy),
    .disp_dst_tag_i(dst),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
    .fu_free_i(fu_free),
    .iss_valid_o(iss_valid), .iss_op_o(iss_op), .iss_src1_o(iss_s1),
    .iss_src2_o(iss_s2), .iss_dst_tag_o(iss_dst));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic              m_busy [NE];
  logic [OP_W-1:0]   m_op   [NE];
  logic [TAG_W-1:0]  m_t1 [NE], m_t2 [NE], m_dst [NE];
  logic [DATA_W-1:0] m_d1 [NE], m_d2 [NE];
  logic              m_v1 [NE], m_v2 [NE];

  // staged stimulus
  logic              n_dv, n_r1, n_r2, n_bv, n_fu;
  logic [OP_W-1:0]   n_op;
  logic [TAG_W-1:0]  n_t1, n_t2, n_dst, n_bt;
  logic [DATA_W-1:0] n_d1, n_d2, n_bd;

  logic              o_valid, o_ready;
  logic [OP_W-1:0]   o_op;
  logic [DATA_W-1:0] o_s1, o_s2;
  logic [TAG_W-1:0]  o_dst;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_issue_idx();
    for (int i = 0; i < NE; i++)
      if (m_busy[i] && m_v1[i] && m_v2[i]) return i;
    return -1;
  endfunction

  function automatic int exp_free_idx();
    for (int i = 0; i < NE; i++)
      if (!m_busy[i]) return i;
    return -1;
  endfunction

  task automatic stage_idle();
    n_dv = 0; n_r1 = 0; n_r2 = 0; n_bv = 0; n_fu = 1;
    n_op = '0; n_t1 = '0; n_t2 = '0; n_dst = '0; n_bt = '0;
    n_d1 = '0; n_d2 = '0; n_bd = '0;
  endtask

  task automatic step();
    int ei, fi;
    @(negedge clk);
    disp_valid = n_dv; op = n_op; t1 = n_t1; d1 = n_d1; s1_rdy = n_r1;
    t2 = n_t2; d2 = n_d2; s2_rdy = n_r2; dst = n_dst;
    bc_valid = n_bv; bc_tag = n_bt; bc_data = n_bd; fu_free = n_fu;
    #1;
    ei = exp_issue_idx();
    fi = exp_free_idx();
    o_valid = iss_valid; o_ready = disp_ready; o_op = iss_op;
    o_s1 = iss_s1; o_s2 = iss_s2; o_dst = iss_dst;
    chk(disp_ready == (fi >= 0), "R2 disp_ready", disp_ready, fi >= 0);
    chk(iss_valid == (ei >= 0 && n_fu), "R6 iss_valid", iss_valid, ei >= 0 && n_fu);
    if (ei >= 0 && n_fu && iss_valid) begin
      chk(iss_dst == m_dst[ei] && iss_op == m_op[ei], "R7 lowest ready slot",
          {iss_op, iss_dst}, {m_op[ei], m_dst[ei]});
      chk(iss_s1 == m_d1[ei] && iss_s2 == m_d2[ei], "R9 operands",
          {iss_s1, iss_s2}, {m_d1[ei], m_d2[ei]});
    end
    @(posedge clk);
    if (ei >= 0 && n_fu) m_busy[ei] = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (n_bv && !m_v1[i] && m_t1[i] == n_bt) begin m_v1[i] = 1; m_d1[i] = n_bd; end
      if (n_bv && !m_v2[i] && m_t2[i] == n_bt) begin m_v2[i] = 1; m_d2[i] = n_bd; end
    end
    if (n_dv && fi >= 0) begin
      m_busy[fi] = 1; m_op[fi] = n_op; m_dst[fi] = n_dst;
      m_t1[fi] = n_t1; m_v1[fi] = n_r1 | (n_bv && n_bt == n_t1);
      m_d1[fi] = n_r1 ? n_d1 : n_bd;
      m_t2[fi] = n_t2; m_v2[fi] = n_r2 | (n_bv && n_bt == n_t2);
      m_d2[fi] = n_r2 ? n_d2 : n_bd;
    end
  endtask

  task automatic stage_disp(input logic [OP_W-1:0] o, input logic [TAG_W-1:0] a,
                            input logic ra, input logic [DATA_W-1:0] da,
                            input logic [TAG_W-1:0] b, input logic rb,
                            input logic [DATA_W-1:0] db, input logic [TAG_W-1:0] d);
    n_dv = 1; n_op = o; n_t1 = a; n_r1 = ra; n_d1 = da;
    n_t2 = b; n_r2 = rb; n_d2 = db; n_dst = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen_refused;
    void'($urandom(32'd20511));
    for (int i = 0; i < NE; i++) begin
      m_busy[i] = 0; m_v1[i] = 0; m_v2[i] = 0; m_op[i] = '0; m_dst[i] = '0;
      m_t1[i] = '0; m_t2[i] = '0; m_d1[i] = '0; m_d2[i] = '0;
    end
    stage_idle();
    disp_valid = 0; op = '0; t1 = '0; t2 = '0; d1 = '0; d2 = '0; s1_rdy = 0;
    s2_rdy = 0; dst = '0; bc_valid = 0; bc_tag = '0; bc_data = '0; fu_free = 1;
    #20 rst_n = 1'b1;

    // R1 reset state
    step();
    chk(!o_valid, "R1 iss_valid after reset", o_valid, 0);
    chk(o_ready, "R1 disp_ready after reset", o_ready, 1);

    // R3 operands available at dispatch
    stage_disp(4'h5, 3'd0, 1, 16'h0011, 3'd0, 1, 16'h0022, 3'd1);
    step();
    stage_idle();
    step();
    chk(o_valid && o_dst == 3'd1 && o_s1 == 16'h0011 && o_s2 == 16'h0022,
        "R3 issue without broadcast", {o_valid, o_dst}, {1'b1, 3'd1});
    step();
    chk(!o_valid && o_ready, "R8 slot released after issue", {o_valid, o_ready}, 2'b01);

    // fill with pending sources, unit busy
    n_fu = 0;
    stage_disp(4'h1, 3'd4, 0, 16'h0, 3'd0, 1, 16'h0102, 3'd2); step();
    stage_disp(4'h2, 3'd5, 0, 16'h0, 3'd5, 0, 16'h0,    3'd3); step();
    stage_disp(4'h3, 3'd6, 0, 16'h0, 3'd6, 0, 16'h0,    3'd4); step();
    stage_disp(4'h4, 3'd0, 1, 16'h0301, 3'd4, 0, 16'h0, 3'd5); step();
    stage_idle(); n_fu = 0;
    stage_disp(4'h7, 3'd0, 1, 16'h0777, 3'd0, 1, 16'h0777, 3'd7); // R10 refused
    step();
    chk(!o_ready, "R2 pool full", o_ready, 0);
    stage_idle(); n_fu = 0;
    n_bv = 1; n_bt = 3'd6; n_bd = 16'h0066;
    step();
    chk(!o_valid, "R6 unit busy", o_valid, 0);
    stage_idle();
    n_fu = 0;
    step();
    chk(!o_valid, "R6 ready slot held while unit busy", o_valid, 0);
    stage_idle();
    step();
    chk(o_valid && o_dst == 3'd4 && o_s1 == 16'h0066 && o_s2 == 16'h0066,
        "R4 R7 younger woken slot issues", o_dst, 4);
    // R5 broadcast with dispatch into freed slot; also wakes slots 0 and 3
    stage_idle();
    stage_disp(4'h6, 3'd4, 0, 16'h0, 3'd0, 1, 16'h0009, 3'd6);
    n_bv = 1; n_bt = 3'd4; n_bd = 16'h0044; n_fu = 0;
    step();
    stage_idle();
    step();
    chk(o_valid && o_dst == 3'd2 && o_s1 == 16'h0044, "R7 lowest of three ready", o_dst, 2);
    step();
    chk(o_valid && o_dst == 3'd6 && o_s1 == 16'h0044 && o_s2 == 16'h0009,
        "R5 same-cycle wake at dispatch", {o_dst, o_s1}, {3'd6, 16'h0044});
    step();
    chk(o_valid && o_dst == 3'd5 && o_s2 == 16'h0044, "R4 shared tag wakes all", o_dst, 5);
    n_bv = 1; n_bt = 3'd1; n_bd = 16'h0bad;
    step();
    chk(!o_valid, "R4 non-matching tag ignored", o_valid, 0);
    stage_idle();
    n_bv = 1; n_bt = 3'd5; n_bd = 16'h0055;
    step();
    stage_idle();
    seen_refused = 0;
    for (int k = 0; k < 4; k++) begin
      step();
      if (o_valid && o_dst == 3'd7) seen_refused = 1;
      if (k == 0) chk(o_valid && o_dst == 3'd3 && o_s1 == 16'h0055 && o_s2 == 16'h0055,
                      "R4 both sources same tag", o_dst, 3);
    end
    chk(!seen_refused && o_ready, "R10 refused dispatch never issues", seen_refused, 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      n_dv = 1'($urandom % 2); n_op = OP_W'($urandom);
      n_t1 = TAG_W'($urandom); n_t2 = TAG_W'($urandom); n_dst = TAG_W'($urandom);
      n_r1 = 1'(($urandom % 3) == 0); n_r2 = 1'(($urandom % 3) == 0);
      n_d1 = DATA_W'($urandom); n_d2 = DATA_W'($urandom);
      n_bv = 1'($urandom % 2); n_bt = TAG_W'($urandom); n_bd = DATA_W'($urandom);
      n_fu = 1'(($urandom % 4) != 0);
      step();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule